// File: doc/BRIEF.md
# Coupled-CORDIC Givens Rotation Element

This element computes a plane (Givens) rotation from one leading pair of matrix entries and applies it to other entry pairs, as needed inside bidiagonalization and implicit-shift SVD sweeps. The leading pair `(x, y)` enters a vectoring CORDIC. That pipeline drives `y` to zero and returns the norm `sqrt(x² + y²)`. A second CORDIC runs in rotation mode beside it. It takes a stream of companion pairs `(u, v)` and applies the same rotation to them. It never forms an angle. Instead, each stage of the vectoring pipeline passes its micro-rotation decision to the matching stage of the companion pipeline. All arithmetic uses shifts and adds. The only multiplication, the gain correction, is a fixed set of shifts and adds.

Every stage keeps the last decision it made. Companion pairs that arrive after their leading pair has moved on are therefore rotated by that same rotation, so a sweep controller can stream as many companion pairs as the current matrix size needs (from 2×2 up to 8×8, or more), with or without gaps. A leading pair marked with the hold input is still vectored, but it leaves the stored rotation unchanged. Both pipelines accept a new pair every cycle and have the same fixed latency.

Top module: `gvn_rot_pe`

## Requirements
- R1: All data ports are 18-bit two's complement Q2.15 (15 fraction bits). For a leading pair with components in [-1, 1), not both zero, `mag_o` equals `sqrt(x²+y²)` within 2^-11.
- R2: Both paths accept one pair per cycle. Each accepted pair comes out exactly 18 cycles after the clock edge that samples it, with its valid output high. Order is preserved, cycles without a valid input produce cycles with no valid output, and every accepted pair produces exactly one result.
- R3: For each leading result, the residual of the zeroed component, `resid_o`, has magnitude below 2^-12.
- R4: A companion pair sampled in the same cycle as a leading pair with hold low is rotated by that pair's rotation: the outputs are `c·u + s·v` and `-s·u + c·v` within 2^-11, with `c = x/r` and `s = y/r`.
- R5: Leading pairs with negative `x`, including x = -1.0, are handled. Their norm follows R1 and their companions follow R4.
- R6: A companion pair sampled in a cycle with no leading pair is rotated, per R4, by the most recent earlier leading pair whose hold was low. This holds for any number of such pairs and for gaps between them.
- R7: A leading pair sampled with `lead_hold_i` high produces its norm per R1 but does not replace the stored rotation. Companions in that cycle and later ones use the previous rotation.
- R8: While reset is low, and after it is released until the first result, both valid outputs are low and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lead_valid_i | input | 1 | Leading pair present this cycle |
| lead_hold_i | input | 1 | Vector this leading pair but keep the stored rotation |
| lead_x_i | input | 18 | Leading pair, component kept (Q2.15) |
| lead_y_i | input | 18 | Leading pair, component to zero (Q2.15) |
| comp_valid_i | input | 1 | Companion pair present this cycle |
| comp_x_i | input | 18 | Companion first component (Q2.15) |
| comp_y_i | input | 18 | Companion second component (Q2.15) |
| mag_valid_o | output | 1 | Leading result valid |
| mag_o | output | 18 | Norm of the leading pair (Q2.15) |
| resid_o | output | 18 | Residual of the zeroed component (Q2.15) |
| comp_valid_o | output | 1 | Companion result valid |
| comp_x_o | output | 18 | Rotated companion first component (Q2.15) |
| comp_y_o | output | 18 | Rotated companion second component (Q2.15) |

## Verification
A wrong decision bit or a wrong stored direction at any stage shows up as a companion result that is off by an angle of at least atan(2^-15). A wrong bit at the first stages gives an error of tens of degrees. The fault appears on the companion outputs exactly 18 cycles after the pair that met that stage entered, while the norm still looks right. For this reason every companion result is checked against a floating-point rotation built from the quantized leading inputs. A hold flag that is lost or misrouted shows only on the companion pairs that follow a held leading pair. A broken pre-rotation shows only for negative `x`. Each of these cases is driven on its own. Valid bits are checked against the exact expected cycle, so any slip in the pipeline is caught on the first affected pair.

// File: rtl/gvn_pkg.sv
package gvn_pkg;

   // Sign of the y component decides each micro-rotation in the vectoring path.
   typedef enum logic {
      ROT_CCW = 1'b0,   // y negative: rotate counter-clockwise
      ROT_CW  = 1'b1    // y non-negative: rotate clockwise
   } rot_dir_e;

   // 1/K ~= 0.6072529 as signed powers of two:
   // 2^-1 + 2^-3 - 2^-6 - 2^-9 - 2^-12 + 2^-14 + 2^-16
   localparam int GAIN_TERMS = 7;
   localparam int GAIN_SHIFT [GAIN_TERMS] = '{1, 3, 6, 9, 12, 14, 16};
   localparam bit GAIN_NEG   [GAIN_TERMS] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

endpackage

// File: rtl/gvn_prerot.sv
// Folds leading pairs with negative x into the right half-plane. The fold is
// remembered so that companion pairs that arrive later get the same negation.
module gvn_prerot import gvn_pkg::*; #(
   parameter int DW = 18,
   parameter int IW = 21
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lv_i,
   input  logic                 hold_i,
   input  logic signed [DW-1:0] lx_i,
   input  logic signed [DW-1:0] ly_i,
   input  logic                 cv_i,
   input  logic signed [DW-1:0] cx_i,
   input  logic signed [DW-1:0] cy_i,
   output logic                 lv_o,
   output logic                 keep_o,
   output logic signed [IW-1:0] lx_o,
   output logic signed [IW-1:0] ly_o,
   output logic                 cv_o,
   output logic signed [IW-1:0] cx_o,
   output logic signed [IW-1:0] cy_o
);
   localparam int GUARD = IW - DW;

   logic                 flip_q;
   logic                 lnew;
   logic                 lflip;
   logic                 cflip;
   logic signed [IW-1:0] lx_e, ly_e, cx_e, cy_e;

   assign lx_e  = {lx_i, {GUARD{1'b0}}};
   assign ly_e  = {ly_i, {GUARD{1'b0}}};
   assign cx_e  = {cx_i, {GUARD{1'b0}}};
   assign cy_e  = {cy_i, {GUARD{1'b0}}};
   assign lnew  = lv_i && !hold_i;
   assign lflip = lx_i[DW-1];
   assign cflip = lnew ? lflip : flip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lv_o   <= 1'b0;
         keep_o <= 1'b0;
         lx_o   <= '0;
         ly_o   <= '0;
         cv_o   <= 1'b0;
         cx_o   <= '0;
         cy_o   <= '0;
         flip_q <= 1'b0;
      end else begin
         lv_o <= lv_i;
         cv_o <= cv_i;
         if (lv_i) begin
            keep_o <= hold_i;
            lx_o   <= lflip ? -lx_e : lx_e;
            ly_o   <= lflip ? -ly_e : ly_e;
         end
         if (cv_i) begin
            cx_o <= cflip ? -cx_e : cx_e;
            cy_o <= cflip ? -cy_e : cy_e;
         end
         if (lnew) flip_q <= lflip;
      end
   end

   // R5: after the fold the leading x is never negative
   a_r5_fold_right_half: assert property (@(posedge clk) disable iff (!rst_n)
      lv_o |-> !lx_o[IW-1]);

   // R7: a held leading pair leaves the stored fold untouched
   a_r7_fold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (lv_i && hold_i) |=> (flip_q == $past(flip_q)));

endmodule

// File: rtl/gvn_cstage.sv
// One micro-rotation for both paths. The vectoring decision drives the
// companion path in the same cycle and is also stored for later companions.
module gvn_cstage import gvn_pkg::*; #(
   parameter int IW    = 21,
   parameter int SHIFT = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lv_i,
   input  logic                 keep_i,
   input  logic signed [IW-1:0] lx_i,
   input  logic signed [IW-1:0] ly_i,
   input  logic                 cv_i,
   input  logic signed [IW-1:0] cx_i,
   input  logic signed [IW-1:0] cy_i,
   output logic                 lv_o,
   output logic                 keep_o,
   output logic signed [IW-1:0] lx_o,
   output logic signed [IW-1:0] ly_o,
   output logic                 cv_o,
   output logic signed [IW-1:0] cx_o,
   output logic signed [IW-1:0] cy_o
);
   rot_dir_e             dir_q;
   rot_dir_e             ldir;
   rot_dir_e             cdir;
   logic                 lnew;
   logic signed [IW-1:0] lx_sh, ly_sh, cx_sh, cy_sh;

   assign lnew  = lv_i && !keep_i;
   assign ldir  = ly_i[IW-1] ? ROT_CCW : ROT_CW;
   assign cdir  = lnew ? ldir : dir_q;
   assign lx_sh = lx_i >>> SHIFT;
   assign ly_sh = ly_i >>> SHIFT;
   assign cx_sh = cx_i >>> SHIFT;
   assign cy_sh = cy_i >>> SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lv_o   <= 1'b0;
         keep_o <= 1'b0;
         lx_o   <= '0;
         ly_o   <= '0;
         cv_o   <= 1'b0;
         cx_o   <= '0;
         cy_o   <= '0;
         dir_q  <= ROT_CCW;
      end else begin
         lv_o <= lv_i;
         cv_o <= cv_i;
         if (lv_i) begin
            keep_o <= keep_i;
            if (ldir == ROT_CW) begin
               lx_o <= lx_i + ly_sh;
               ly_o <= ly_i - lx_sh;
            end else begin
               lx_o <= lx_i - ly_sh;
               ly_o <= ly_i + lx_sh;
            end
         end
         if (cv_i) begin
            if (cdir == ROT_CW) begin
               cx_o <= cx_i + cy_sh;
               cy_o <= cy_i - cx_sh;
            end else begin
               cx_o <= cx_i - cy_sh;
               cy_o <= cy_i + cx_sh;
            end
         end
         if (lnew) dir_q <= ldir;
      end
   end

   // R2: each stage adds exactly one cycle and keeps bubbles
   a_r2_lead_step:   assert property (@(posedge clk) disable iff (!rst_n) lv_i  |=> lv_o);
   a_r2_lead_bubble: assert property (@(posedge clk) disable iff (!rst_n) !lv_i |=> !lv_o);
   a_r2_comp_step:   assert property (@(posedge clk) disable iff (!rst_n) cv_i  |=> cv_o);
   a_r2_comp_bubble: assert property (@(posedge clk) disable iff (!rst_n) !cv_i |=> !cv_o);

   // R1: the vectoring x never leaves the right half-plane
   a_r1_x_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
      lv_o |-> !lx_o[IW-1]);

   // R7: a held leading pair does not overwrite the stored direction
   a_r7_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (lv_i && keep_i) |=> (dir_q == $past(dir_q)));

endmodule

// File: rtl/gvn_gain.sv
// Removes the CORDIC gain with a fixed shift-add constant, then rounds away
// the guard bits and registers the result.
module gvn_gain import gvn_pkg::*; #(
   parameter int DW = 18,
   parameter int IW = 21
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_i,
   input  logic signed [IW-1:0] a_i,
   input  logic signed [IW-1:0] b_i,
   output logic                 v_o,
   output logic signed [DW-1:0] a_o,
   output logic signed [DW-1:0] b_o
);
   localparam int GUARD = IW - DW;
   localparam logic signed [IW:0] HALF = (IW+1)'(1) << (GUARD - 1);

   function automatic logic signed [IW-1:0] unscale(input logic signed [IW-1:0] d);
      logic signed [IW-1:0] acc;
      acc = '0;
      for (int k = 0; k < GAIN_TERMS; k++) begin
         if (GAIN_NEG[k]) acc = acc - (d >>> GAIN_SHIFT[k]);
         else             acc = acc + (d >>> GAIN_SHIFT[k]);
      end
      return acc;
   endfunction

   function automatic logic signed [DW-1:0] trim(input logic signed [IW-1:0] s);
      logic signed [IW:0] t;
      t = {s[IW-1], s} + HALF;
      return t[GUARD+DW-1:GUARD];
   endfunction

   logic signed [DW-1:0] a_n, b_n;
   assign a_n = trim(unscale(a_i));
   assign b_n = trim(unscale(b_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o <= 1'b0;
         a_o <= '0;
         b_o <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) begin
            a_o <= a_n;
            b_o <= b_n;
         end
      end
   end

   // R2: the gain stage forwards validity by exactly one cycle
   a_r2_gain_step: assert property (@(posedge clk) disable iff (!rst_n)
      v_i |=> v_o);

endmodule

// File: rtl/gvn_rot_pe.sv
module gvn_rot_pe import gvn_pkg::*; #(
   parameter int DW    = 18,
   parameter int ITER  = 16,
   parameter int GUARD = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lead_valid_i,
   input  logic                 lead_hold_i,
   input  logic signed [DW-1:0] lead_x_i,
   input  logic signed [DW-1:0] lead_y_i,
   input  logic                 comp_valid_i,
   input  logic signed [DW-1:0] comp_x_i,
   input  logic signed [DW-1:0] comp_y_i,
   output logic                 mag_valid_o,
   output logic signed [DW-1:0] mag_o,
   output logic signed [DW-1:0] resid_o,
   output logic                 comp_valid_o,
   output logic signed [DW-1:0] comp_x_o,
   output logic signed [DW-1:0] comp_y_o
);
   localparam int IW = DW + GUARD;

   if (DW < 8) begin : g_bad_dw
      $error("gvn_rot_pe: DW must be at least 8");
   end
   if (ITER < 4 || ITER > DW) begin : g_bad_iter
      $error("gvn_rot_pe: ITER must lie in 4..DW");
   end
   if (GUARD < 1 || GUARD > 8) begin : g_bad_guard
      $error("gvn_rot_pe: GUARD must lie in 1..8");
   end

   logic                 lv   [ITER+1];
   logic                 keep [ITER+1];
   logic signed [IW-1:0] lx   [ITER+1];
   logic signed [IW-1:0] ly   [ITER+1];
   logic                 cv   [ITER+1];
   logic signed [IW-1:0] cx   [ITER+1];
   logic signed [IW-1:0] cy   [ITER+1];
   logic                 unused_keep_tail;

   assign unused_keep_tail = keep[ITER];

   gvn_prerot #(.DW(DW), .IW(IW)) u_prerot (
      .clk    (clk),
      .rst_n  (rst_n),
      .lv_i   (lead_valid_i),
      .hold_i (lead_hold_i),
      .lx_i   (lead_x_i),
      .ly_i   (lead_y_i),
      .cv_i   (comp_valid_i),
      .cx_i   (comp_x_i),
      .cy_i   (comp_y_i),
      .lv_o   (lv[0]),
      .keep_o (keep[0]),
      .lx_o   (lx[0]),
      .ly_o   (ly[0]),
      .cv_o   (cv[0]),
      .cx_o   (cx[0]),
      .cy_o   (cy[0])
   );

   for (genvar i = 0; i < ITER; i++) begin : g_stage
      gvn_cstage #(.IW(IW), .SHIFT(i)) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .lv_i   (lv[i]),
         .keep_i (keep[i]),
         .lx_i   (lx[i]),
         .ly_i   (ly[i]),
         .cv_i   (cv[i]),
         .cx_i   (cx[i]),
         .cy_i   (cy[i]),
         .lv_o   (lv[i+1]),
         .keep_o (keep[i+1]),
         .lx_o   (lx[i+1]),
         .ly_o   (ly[i+1]),
         .cv_o   (cv[i+1]),
         .cx_o   (cx[i+1]),
         .cy_o   (cy[i+1])
      );
   end

   gvn_gain #(.DW(DW), .IW(IW)) u_gain_lead (
      .clk   (clk),
      .rst_n (rst_n),
      .v_i   (lv[ITER]),
      .a_i   (lx[ITER]),
      .b_i   (ly[ITER]),
      .v_o   (mag_valid_o),
      .a_o   (mag_o),
      .b_o   (resid_o)
   );

   gvn_gain #(.DW(DW), .IW(IW)) u_gain_comp (
      .clk   (clk),
      .rst_n (rst_n),
      .v_i   (cv[ITER]),
      .a_i   (cx[ITER]),
      .b_i   (cy[ITER]),
      .v_o   (comp_valid_o),
      .a_o   (comp_x_o),
      .b_o   (comp_y_o)
   );

   // R1: a reported norm is never negative
   a_r1_mag_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
      mag_valid_o |-> !mag_o[DW-1]);

   // R8: outputs stay cleared while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_r8_reset_quiet: assert (!mag_valid_o && !comp_valid_o && mag_o == '0 && comp_x_o == '0);
      end
   end

endmodule

// File: tb/test_gvn_rot_pe.sv
`timescale 1ns/1ps
module test_gvn_rot_pe;
   localparam int  DW   = 18;
   localparam int  ITER = 16;
   localparam int  LAT  = ITER + 2;
   localparam real ONE  = 32768.0;
   localparam real TOL  = 1.0 / 2048.0;   // 2^-11
   localparam real RTOL = 1.0 / 4096.0;   // 2^-12

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lead_valid_i = 1'b0, lead_hold_i = 1'b0, comp_valid_i = 1'b0;
   logic signed [DW-1:0] lead_x_i = '0, lead_y_i = '0, comp_x_i = '0, comp_y_i = '0;
   logic mag_valid_o, comp_valid_o;
   logic signed [DW-1:0] mag_o, resid_o, comp_x_o, comp_y_o;

   gvn_rot_pe #(.DW(DW), .ITER(ITER), .GUARD(3)) i_gvn_rot_pe (
      .clk(clk), .rst_n(rst_n),
      .lead_valid_i(lead_valid_i), .lead_hold_i(lead_hold_i),
      .lead_x_i(lead_x_i), .lead_y_i(lead_y_i),
      .comp_valid_i(comp_valid_i), .comp_x_i(comp_x_i), .comp_y_i(comp_y_i),
      .mag_valid_o(mag_valid_o), .mag_o(mag_o), .resid_o(resid_o),
      .comp_valid_o(comp_valid_o), .comp_x_o(comp_x_o), .comp_y_o(comp_y_o)
   );

   always #2 clk = ~clk;   // 250 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_bad = 0;
   bit monitor_on = 1'b0;

   real   el_mag [256]; int el_cyc [256]; string el_tag [256]; int el_wr = 0, el_rd = 0;
   real   ec_u [512]; real ec_v [512]; int ec_cyc [512]; string ec_tag [512];
   int    ec_wr = 0, ec_rd = 0;
   real   cur_c = 1.0, cur_s = 0.0;

   function automatic int r2fx(real r);
      if (r >= 0.0) return $rtoi(r * ONE + 0.5);
      return -$rtoi(-r * ONE + 0.5);
   endfunction

   function automatic real fx2r(logic signed [DW-1:0] v);
      return $itor(v) / ONE;
   endfunction

   function automatic real fabs(real r);
      return (r < 0.0) ? -r : r;
   endfunction

   task automatic chk_real(string req, string what, real act, real exp, real tol);
      n_chk++;
      if (fabs(act - exp) > tol) begin
         n_bad++;
         $display("FAIL %s %s: actual %f expected %f", req, what, act, exp);
      end
   endtask

   task automatic chk_int(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Output monitor: compares each result with the queued expectation
   always @(negedge clk) begin
      if (monitor_on) begin
         if (mag_valid_o) begin
            if (el_rd == el_wr) chk_int("R2", "unexpected leading result count", 1, 0);
            else begin
               chk_real(el_tag[el_rd], "norm", fx2r(mag_o), el_mag[el_rd], TOL);
               chk_real("R3", "residual", fabs(fx2r(resid_o)), 0.0, RTOL);
               chk_int("R2", "leading latency", cyc - el_cyc[el_rd], LAT);
               el_rd++;
            end
         end
         if (comp_valid_o) begin
            if (ec_rd == ec_wr) chk_int("R2", "unexpected companion result count", 1, 0);
            else begin
               chk_real(ec_tag[ec_rd], "companion x", fx2r(comp_x_o), ec_u[ec_rd], TOL);
               chk_real(ec_tag[ec_rd], "companion y", fx2r(comp_y_o), ec_v[ec_rd], TOL);
               chk_int("R2", "companion latency", cyc - ec_cyc[ec_rd], LAT);
               ec_rd++;
            end
         end
      end
   end

   // Drives one cycle of input and records what must come out of it
   task automatic drive(bit lv, bit hold, real x, real y, bit cv, real u, real v, string ctag);
      real xq, yq, uq, vq, r;
      @(negedge clk);
      lead_valid_i = lv;
      lead_hold_i  = hold;
      lead_x_i     = DW'(r2fx(x));
      lead_y_i     = DW'(r2fx(y));
      comp_valid_i = cv;
      comp_x_i     = DW'(r2fx(u));
      comp_y_i     = DW'(r2fx(v));
      xq = fx2r(lead_x_i); yq = fx2r(lead_y_i);
      uq = fx2r(comp_x_i); vq = fx2r(comp_y_i);
      if (lv) begin
         r = $sqrt(xq * xq + yq * yq);
         el_mag[el_wr] = r; el_cyc[el_wr] = cyc; el_tag[el_wr] = "R1"; el_wr++;
         if (!hold) begin cur_c = xq / r; cur_s = yq / r; end
      end
      if (cv) begin
         ec_u[ec_wr] = cur_c * uq + cur_s * vq;
         ec_v[ec_wr] = -cur_s * uq + cur_c * vq;
         ec_cyc[ec_wr] = cyc; ec_tag[ec_wr] = ctag; ec_wr++;
      end
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 0.0, 0.0, 1'b0, 0.0, 0.0, "");
   endtask

   task automatic t_reset;   // R8
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_int("R8", "valids in reset", {30'd0, mag_valid_o, comp_valid_o}, 0);
      chk_int("R8", "data in reset", int'(mag_o) | int'(comp_x_o) | int'(comp_y_o) | int'(resid_o), 0);
      rst_n = 1'b1;
      monitor_on = 1'b1;
      idle(4);
      chk_int("R8", "valids after release", {30'd0, mag_valid_o, comp_valid_o}, 0);
      chk_int("R8", "data after release", int'(mag_o) | int'(comp_x_o), 0);
   endtask

   task automatic t_basic;   // R1, R3, R4
      drive(1'b1, 1'b0, 0.6, 0.3, 1'b1, 0.5, -0.25, "R4");
      drive(1'b1, 1'b0, 0.2, 0.7, 1'b1, -0.4, 0.9, "R4");
      drive(1'b1, 1'b0, 0.9, -0.6, 1'b1, 0.75, 0.1, "R4");
      idle(LAT + 2);
   endtask

   task automatic t_left_half;   // R5, back-to-back for R2
      drive(1'b1, 1'b0, -0.5, 0.4, 1'b1, 0.3, 0.6, "R5");
      drive(1'b1, 1'b0, -0.9, -0.1, 1'b1, -0.7, 0.2, "R5");
      drive(1'b1, 1'b0, -0.3, -0.8, 1'b1, 0.5, 0.5, "R5");
      drive(1'b1, 1'b0, 0.0, -0.75, 1'b1, 0.4, -0.9, "R5");
      drive(1'b1, 1'b0, -1.0, -1.0, 1'b1, 0.99, -1.0, "R5");
      drive(1'b1, 1'b0, -0.05, 0.99, 1'b1, -0.6, -0.6, "R5");
      idle(LAT + 2);
   endtask

   task automatic t_stream;   // R6
      drive(1'b1, 1'b0, 0.8, -0.45, 1'b1, 0.1, 0.2, "R6");
      for (int k = 0; k < 7; k++)
         drive(1'b0, 1'b0, 0.0, 0.0, 1'b1, 0.9 - 0.25 * k, -0.5 + 0.2 * k, "R6");
      idle(2);
      drive(1'b1, 1'b0, -0.1, 0.95, 1'b0, 0.0, 0.0, "R6");
      drive(1'b0, 1'b0, 0.0, 0.0, 1'b1, 0.7, 0.3, "R6");
      idle(1);
      drive(1'b0, 1'b0, 0.0, 0.0, 1'b1, -0.2, -0.85, "R6");
      idle(3);
      drive(1'b0, 1'b0, 0.0, 0.0, 1'b1, 0.55, -0.15, "R6");
      idle(LAT + 2);
   endtask

   task automatic t_hold;   // R7
      drive(1'b1, 1'b0, 0.5, 0.5, 1'b1, 0.8, 0.0, "R7");
      drive(1'b1, 1'b1, -0.9, -0.3, 1'b1, 0.0, 0.8, "R7");
      drive(1'b0, 1'b0, 0.0, 0.0, 1'b1, -0.6, 0.4, "R7");
      drive(1'b1, 1'b1, 0.1, -0.9, 1'b0, 0.0, 0.0, "R7");
      drive(1'b0, 1'b0, 0.0, 0.0, 1'b1, 0.3, -0.7, "R7");
      drive(1'b1, 1'b0, 0.6, -0.2, 1'b1, 0.4, 0.4, "R7");
      drive(1'b0, 1'b0, 0.0, 0.0, 1'b1, -0.9, 0.1, "R7");
      idle(LAT + 2);
   endtask

   bit timed_out = 1'b0;

   initial begin
      fork
         begin
            t_reset();
            t_basic();
            t_left_half();
            t_stream();
            t_hold();
         end
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_chk++; n_bad++;
         $display("FAIL R2 watchdog: actual timeout expected completion");
      end
      chk_int("R2", "leading results delivered", el_rd, el_wr);
      chk_int("R2", "companion results delivered", ec_rd, ec_wr);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule